// File: doc/BRIEF.md
# Dual-Input Capture Timer Channel

This block is a single timer channel working in capture mode. A free-running 16-bit up-counter advances once every (prescale + 1) active clocks. Two external inputs each pass through a synchronizer and an edge qualifier with its own edge-select field. A qualified edge on input A copies the counter into the period-capture register. A qualified edge on input B copies it into the duty-capture register. Either capture can optionally restart the counter from zero. The block emits single-cycle strobes for each capture and for counter wrap-around. A separate interrupt block is expected to consume these strobes.

Software reaches the block through a plain register port: a write strobe, a 3-bit address and 16-bit write data, with combinational read data. The block has no streaming data path, so every pin is a plain level or a one-clock strobe. No port carries back-pressure, and software may write every cycle. A debug freeze input halts counting and masks captures while it is asserted. A low-power bit stops the counter and prescaler and blocks writes to the counter and capture registers.

Top module: `cap_timer_chan`

## Requirements
- R1: After reset, every register reads zero and all three strobes are low.
- R2: The register map is as follows.
  - Address 0 is the control register. Bit 0 is run and bit 1 is low-power. Bits [3:2] are the mode. Bits [5:4] select the edge for input A and bits [7:6] select the edge for input B. Bit 8 enables restart on an input-A capture and bit 9 enables restart on an input-B capture.
  - Address 1 is the 8-bit prescale value, address 2 is the counter, address 3 is period-capture and address 4 is duty-capture.
  - Other addresses read zero.
- R3: While counting is active, the counter advances once per (prescale + 1) clocks. A write to the counter also restarts the prescaler phase from zero.
- R4: A qualified edge on input A loads the period-capture register with the count held before that edge's capture clock. The period strobe pulses high for exactly that one cycle. The capture lands three clocks after the input changes.
- R5: A qualified edge on input B loads the duty-capture register in the same way and pulses the duty strobe.
- R6: The edge-select encoding is 00 = none, 01 = rising, 10 = falling and 11 = both. An unselected edge leaves the capture register and strobe untouched.
- R7: When restart is enabled for an input, its capture clears the counter. The capture register receives the count from before the restart.
- R8: When the counter wraps from 0xFFFF to 0x0000 on a count enable, the overflow strobe is high for one clock.
- R9: Counting and captures occur only when the mode field equals 11. Counting also requires the run bit.
- R10: While freeze is high, the counter holds and capture edges are discarded. After freeze falls, counting resumes from the held value.
- R11: In low-power mode, the counter and the prescaler hold their values. Writes to the counter, period and duty registers are ignored, but the control and prescale registers stay writable and every register stays readable.
- R12: When a capture and a bus write target the same capture register in one cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Debug halt: stops counting, masks captures |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| cap_in_a | input | 1 | Asynchronous capture input A (period) |
| cap_in_b | input | 1 | Asynchronous capture input B (duty) |
| evt_percap | output | 1 | Period-capture strobe |
| evt_dtycap | output | 1 | Duty-capture strobe |
| evt_ovf | output | 1 | Counter overflow strobe |

## Verification
The capture path is driven from a vector table that varies the prescale value, the delay before the edge, the edge polarity, the edge-select field and the input channel. Because the captured value depends on prescale division and on the three-clock synchronizer latency together, an off-by-one in either one shows up as a wrong count. Each pairing of an unselected polarity with a select code must leave a preloaded marker value in place, so the decoding of the select bits is separated from the edge detection. Directed cases then cover the following:
- a restart on the capturing clock, which separates the pre-restart value from zero;
- a wrap from 0xFFFE;
- freeze with an edge arriving during the halt;
- low-power entry with rejected and accepted writes;
- mode and run gating.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_PRESC  = 3'd1,
    RA_COUNT  = 3'd2,
    RA_PERCAP = 3'd3,
    RA_DTYCAP = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [1:0] MODE_CAPTURE = 2'b11;

  // control register layout, msb first
  typedef struct packed {
    logic      rst_b;
    logic      rst_a;
    edge_sel_e sel_b;
    edge_sel_e sel_a;
    logic [1:0] mode;
    logic      lp;
    logic      run;
  } ctrl_t;

endpackage

// File: rtl/cap_edge_qual.sv
module cap_edge_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
  // bit 0 selects rising, bit 1 selects falling
  assign evt  = (sel[0] & rise) | (sel[1] & fall);

  AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (lvl != prev_q)); // R6
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic             hit;

  assign hit  = (pre_q == limit);
  assign tick = en & hit & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
    end else if (en) begin
      pre_q <= hit ? '0 : pre_q + 1'b1;
    end
  end

  AST_PRE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(pre_q)); // R11
endmodule

// File: rtl/cap_count_core.sv
module cap_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             lp,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic             rst_on_a,
  input  logic             rst_on_b,
  input  logic             wr_cnt,
  input  logic             wr_per,
  input  logic             wr_dty,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] dty,
  output logic             evt_per,
  output logic             evt_dty,
  output logic             evt_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, per_q, dty_q;
  logic             per_ev_q, dty_ev_q, ovf_q;
  logic             restart;
  logic             wr_cnt_ok, wr_per_ok, wr_dty_ok;

  assign restart   = (cap_a & rst_on_a) | (cap_b & rst_on_b);
  assign wr_cnt_ok = wr_cnt & ~lp;
  assign wr_per_ok = wr_per & ~lp;
  assign wr_dty_ok = wr_dty & ~lp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_q    <= '0;
      dty_q    <= '0;
      per_ev_q <= 1'b0;
      dty_ev_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      per_ev_q <= cap_a;
      dty_ev_q <= cap_b;
      ovf_q    <= 1'b0;
      if (wr_cnt_ok) begin
        cnt_q <= wdata;
      end else if (restart) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        ovf_q <= (cnt_q == CNT_MAX);
      end
      if (cap_a)          per_q <= cnt_q;
      else if (wr_per_ok) per_q <= wdata;
      if (cap_b)          dty_q <= cnt_q;
      else if (wr_dty_ok) dty_q <= wdata;
    end
  end

  assign cnt     = cnt_q;
  assign per     = per_q;
  assign dty     = dty_q;
  assign evt_per = per_ev_q;
  assign evt_dty = dty_ev_q;
  assign evt_ovf = ovf_q;

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0)); // R8
  AST_PER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    per_ev_q |-> (per_q == $past(cnt_q))); // R4
  AST_DTY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dty_ev_q |-> (dty_q == $past(cnt_q))); // R5
  AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lp && !cap_a && !cap_b) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cap_in_a,
  input  logic             cap_in_b,
  output logic             evt_percap,
  output logic             evt_dtycap,
  output logic             evt_ovf
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int NCH    = 2;

  ctrl_t            ctrl_q;
  logic [PRE_W-1:0] presc_q;
  reg_addr_e        addr;
  logic             mode_cap, count_act, cap_en;
  logic             wr_ctrl, wr_presc, wr_cnt, wr_per, wr_dty;
  logic             tick;
  logic [NCH-1:0]   raw_evt;
  logic [NCH-1:0]   cap_ok;
  logic [1:0]       sel_v [NCH];
  logic [NCH-1:0]   pin_v;
  logic [CNT_W-1:0] cnt, per, dty;
  logic             unused_wdata;

  assign addr     = reg_addr_e'(bus_addr);
  assign wr_ctrl  = bus_we && (addr == RA_CTRL);
  assign wr_presc = bus_we && (addr == RA_PRESC);
  assign wr_cnt   = bus_we && (addr == RA_COUNT);
  assign wr_per   = bus_we && (addr == RA_PERCAP);
  assign wr_dty   = bus_we && (addr == RA_DTYCAP);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_presc) presc_q <= bus_wdata[PRE_W-1:0];
    end
  end

  assign mode_cap  = (ctrl_q.mode == MODE_CAPTURE);
  assign cap_en    = mode_cap && !freeze && !ctrl_q.lp;
  assign count_act = cap_en && ctrl_q.run;

  assign sel_v[0] = ctrl_q.sel_a;
  assign sel_v[1] = ctrl_q.sel_b;
  assign pin_v    = {cap_in_b, cap_in_a};

  for (genvar g = 0; g < NCH; g++) begin : g_in
    cap_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk (clk),
      .rst_n (rst_n),
      .pin (pin_v[g]),
      .sel (sel_v[g]),
      .evt (raw_evt[g])
    );
    assign cap_ok[g] = raw_evt[g] & cap_en;
  end

  cap_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (count_act),
    .clr   (wr_cnt && !ctrl_q.lp),
    .limit (presc_q),
    .tick  (tick)
  );

  cap_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .lp       (ctrl_q.lp),
    .cap_a    (cap_ok[0]),
    .cap_b    (cap_ok[1]),
    .rst_on_a (ctrl_q.rst_a),
    .rst_on_b (ctrl_q.rst_b),
    .wr_cnt   (wr_cnt),
    .wr_per   (wr_per),
    .wr_dty   (wr_dty),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .per      (per),
    .dty      (dty),
    .evt_per  (evt_percap),
    .evt_dty  (evt_dtycap),
    .evt_ovf  (evt_ovf)
  );

  always_comb begin
    case (addr)
      RA_CTRL:   bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      RA_PRESC:  bus_rdata = {{(CNT_W-PRE_W){1'b0}}, presc_q};
      RA_COUNT:  bus_rdata = cnt;
      RA_PERCAP: bus_rdata = per;
      RA_DTYCAP: bus_rdata = dty;
      default:   bus_rdata = '0;
    endcase
  end

  AST_FREEZE_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !(evt_percap || evt_dtycap)); // R10
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_cnt) |=> $stable(cnt)); // R10
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cap && !wr_cnt) |=> ($stable(cnt) && !evt_ovf)); // R9
endmodule

// File: tb/cap_timer_chan_bench.sv
`timescale 1ns/1ps
module cap_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cap_in_a = 1'b0;
  logic        cap_in_b = 1'b0;
  logic        evt_percap, evt_dtycap, evt_ovf;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  cap_timer_chan u_cap_timer_chan (
    .clk (clk), .rst_n (rst_n), .freeze (freeze),
    .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .cap_in_a (cap_in_a), .cap_in_b (cap_in_b),
    .evt_percap (evt_percap), .evt_dtycap (evt_dtycap), .evt_ovf (evt_ovf)
  );

  // {chan, sel, rise, presc, delay, expected capture, expected strobe}
  localparam logic [36:0] VECS [11] = '{
    {1'b0, 2'b01, 1'b1, 8'd0, 8'd10, 16'd12,     1'b1},
    {1'b0, 2'b01, 1'b1, 8'd3, 8'd20, 16'd5,      1'b1},
    {1'b0, 2'b10, 1'b0, 8'd2, 8'd7,  16'd3,      1'b1},
    {1'b0, 2'b11, 1'b1, 8'd0, 8'd0,  16'd2,      1'b1},
    {1'b0, 2'b11, 1'b0, 8'd0, 8'd5,  16'd7,      1'b1},
    {1'b0, 2'b10, 1'b1, 8'd0, 8'd4,  16'hBEEF,   1'b0},
    {1'b0, 2'b00, 1'b0, 8'd0, 8'd4,  16'hBEEF,   1'b0},
    {1'b0, 2'b01, 1'b1, 8'd4, 8'd30, 16'd6,      1'b1},
    {1'b1, 2'b01, 1'b1, 8'd1, 8'd9,  16'd5,      1'b1},
    {1'b1, 2'b10, 1'b1, 8'd0, 8'd3,  16'hBEEF,   1'b0},
    {1'b1, 2'b11, 1'b0, 8'd1, 8'd12, 16'd7,      1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reg reset", v, 16'h0);
    end
    chk("R1 strobes", {13'd0, evt_percap, evt_dtycap, evt_ovf}, 16'h0);
    rd(3'd6, v); chk("R2 unmapped address", v, 16'h0);

    // table: R3 R4 R5 R6
    for (int k = 0; k < 11; k++) begin
      logic        ch, rs, ev;
      logic [1:0]  sl;
      logic [7:0]  p, n;
      logic [15:0] ex;
      {ch, sl, rs, p, n, ex, ev} = VECS[k];
      wr(3'd0, 16'h000D | (16'(sl) << (ch ? 6 : 4)));
      wr(3'd1, {8'd0, p});
      if (ch) cap_in_b = ~rs; else cap_in_a = ~rs;
      idle(4);
      wr(ch ? 3'd4 : 3'd3, 16'hBEEF);
      wr(3'd2, 16'd0);
      idle(int'(n));
      if (ch) cap_in_b = rs; else cap_in_a = rs;
      idle(3);
      rd(ch ? 3'd4 : 3'd3, v);
      chk(ch ? "R5 R6 duty capture" : "R4 R6 period capture", v, ex);
      chk("R4 R5 capture strobe", {15'd0, ch ? evt_dtycap : evt_percap}, {15'd0, ev});
      idle(1);
      chk("R4 strobe one cycle", {14'd0, evt_dtycap, evt_percap}, 16'h0);
    end

    // R7 restart with pre-restart capture
    cap_in_a = 1'b0;
    wr(3'd0, 16'h011D);
    wr(3'd1, 16'd0);
    idle(4);
    wr(3'd3, 16'hBEEF);
    wr(3'd2, 16'd0);
    idle(5);
    cap_in_a = 1'b1;
    idle(3);
    rd(3'd3, v); chk("R7 pre-restart value", v, 16'd7);
    rd(3'd2, v); chk("R7 counter cleared", v, 16'd0);
    idle(1);
    rd(3'd2, v); chk("R7 counting resumes", v, 16'd1);

    // R8 overflow
    wr(3'd0, 16'h000D);
    wr(3'd2, 16'hFFFE);
    idle(1);
    chk("R8 no early ovf", {15'd0, evt_ovf}, 16'd0);
    idle(1);
    rd(3'd2, v); chk("R8 wrapped", v, 16'd0);
    chk("R8 ovf strobe", {15'd0, evt_ovf}, 16'd1);
    idle(1);
    chk("R8 ovf one cycle", {15'd0, evt_ovf}, 16'd0);

    // R10 freeze
    cap_in_a = 1'b0;
    wr(3'd0, 16'h001D);
    idle(4);
    wr(3'd3, 16'hBEEF);
    wr(3'd2, 16'd0);
    idle(3);
    freeze = 1'b1;
    idle(2);
    cap_in_a = 1'b1;
    idle(5);
    rd(3'd2, v); chk("R10 count held", v, 16'd3);
    rd(3'd3, v); chk("R10 capture masked", v, 16'hBEEF);
    freeze = 1'b0;
    idle(2);
    rd(3'd2, v); chk("R10 resume", v, 16'd5);

    // R11 low power
    wr(3'd3, 16'h0AAA);
    wr(3'd2, 16'h0100);
    wr(3'd0, 16'h000F);
    wr(3'd2, 16'h1234);
    wr(3'd3, 16'h5555);
    wr(3'd1, 16'h0007);
    idle(3);
    rd(3'd2, v); chk("R11 count write blocked and held", v, 16'h0101);
    rd(3'd3, v); chk("R11 capture write blocked", v, 16'h0AAA);
    rd(3'd1, v); chk("R11 prescale writable", v, 16'h0007);
    rd(3'd0, v); chk("R2 R11 ctrl readable", v, 16'h000F);
    wr(3'd0, 16'h000D);
    idle(7);
    rd(3'd2, v); chk("R11 prescaler phase held", v, 16'h0101);
    idle(1);
    rd(3'd2, v); chk("R3 R11 tick after 8", v, 16'h0102);

    // R9 run and mode gating
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h000C);
    wr(3'd2, 16'd5);
    idle(4);
    rd(3'd2, v); chk("R9 run off holds", v, 16'd5);
    wr(3'd0, 16'h0015);
    cap_in_a = 1'b0;
    idle(4);
    wr(3'd3, 16'hBEEF);
    cap_in_a = 1'b1;
    idle(4);
    rd(3'd2, v); chk("R9 mode not capture holds", v, 16'd5);
    rd(3'd3, v); chk("R9 mode not capture no capture", v, 16'hBEEF);

    // R12 capture beats bus write
    cap_in_a = 1'b0;
    wr(3'd0, 16'h001D);
    idle(4);
    wr(3'd2, 16'd0);
    cap_in_a = 1'b1;
    idle(2);
    wr(3'd3, 16'h4321);
    rd(3'd3, v); chk("R12 capture wins", v, 16'd2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule